// File: doc/BRIEF.md
# Aliased Bit-Access Control Register Bank

This block holds a small set of 32-bit control and status registers for a peripheral. Each register occupies a 16-byte slot on a simple synchronous bus. Bits [3:2] of the address inside a slot choose how a write is applied to the register:

- a plain load,
- a bitwise OR (set),
- a bitwise AND-NOT (clear),
- a bitwise XOR (toggle).

Software can therefore raise, drop or flip single bits in one bus write, with no read-modify-write sequence. Another master cannot change the register between a read and a write, so no update is lost that way.

The peripheral core sees every register value directly on a flat output vector. The core drives a hardware input vector whose meaning depends on the register kind:

- For a read/write register it carries per-bit set pulses for status flags. A set pulse overrides any software change to the same bit in the same cycle.
- For a read-only register it carries the value the register captures every clock.

A parameter gives each register's reset value and marks which registers are read-only.

Top module: `alias_regbank`

## Requirements
- R1: While `rst` is high, every register loads its parameter reset value. `bus_rdata` is 0 on the clock after a cycle with `rst` high.
- R2: A write with address bits [3:2] = 00 to a mapped read/write slot loads `bus_wdata` into that register on the clock edge.
- R3: A write with address bits [3:2] = 01 ORs `bus_wdata` into the register.
- R4: A write with address bits [3:2] = 10 forces to 0 every bit that is 1 in `bus_wdata`, and keeps the other bits.
- R5: A write with address bits [3:2] = 11 inverts every bit that is 1 in `bus_wdata`.
- R6: A read at any of the four aliases of a slot returns the register's current value on `bus_rdata` one clock after `bus_rd`. A read issued in the same cycle as a write returns the value from before the write. Address bits [1:0] are ignored. `bus_rdata` holds its value in cycles with no read.
- R7: A read-only register (its `RO_MASK` bit set) captures its word of `hw_in` on every clock. Writes to any of its aliases have no effect.
- R8: For a read/write register, a 1 in `hw_in` forces that bit to 1 on the next edge. This overrides a software clear, toggle or plain write in the same cycle.
- R9: A slot whose index (address bits [ADDR_W-1:4]) is NUM_REGS or more is unmapped. It reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address: slot index in [ADDR_W-1:4], access mode in [3:2] |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data or bit mask |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| hw_in | input | NUM_REGS*DATA_W | Set pulses for read/write registers, captured value for read-only registers |
| reg_q | output | NUM_REGS*DATA_W | All register values, register i at bits [i*DATA_W +: DATA_W] |

## Verification
A wrong mode decode shows on `reg_q` at the edge that takes the write. It appears as a word that differs from the OR, AND-NOT or XOR of the old value and the mask. A wrong slot decode shows on the same edge as a change in a neighbouring register or in no register. A lost hardware set pulse leaves a flag at 0 on the clock after the pulse. Read-path faults appear on `bus_rdata` one clock after the read strobe, as a stale value, the value after the write, or nonzero data from an unmapped slot.

// File: rtl/alias_regbank_pkg.sv
package alias_regbank_pkg;

  // Access mode carried in address bits [3:2] of each 16-byte slot.
  typedef enum logic [1:0] {
    ACC_LOAD   = 2'b00,
    ACC_OR     = 2'b01,
    ACC_ANDN   = 2'b10,
    ACC_XOR    = 2'b11
  } acc_mode_e;

  localparam int SLOT_LSB = 4;
  localparam int MODE_LSB = 2;

endpackage

// File: rtl/alias_decode.sv
module alias_decode
  import alias_regbank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:2]  addr_hi,
  output logic               hit,
  output logic [IDX_W-1:0]   idx,
  output acc_mode_e          mode
);

  localparam int SLOT_W = ADDR_W - SLOT_LSB;

  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot = addr_hi[ADDR_W-1:SLOT_LSB];
    hit  = (int'(slot) < NUM_REGS);
    idx  = slot[IDX_W-1:0];
    mode = acc_mode_e'(addr_hi[MODE_LSB+1:MODE_LSB]);
  end

endmodule

// File: rtl/alias_rw_cell.sv
module alias_rw_cell
  import alias_regbank_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  acc_mode_e         mode,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] sw_next;

  always_comb begin
    sw_next = q;
    if (wr_en) begin
      unique case (mode)
        ACC_LOAD: sw_next = wdata;
        ACC_OR:   sw_next = q | wdata;
        ACC_ANDN: sw_next = q & ~wdata;
        ACC_XOR:  sw_next = q ^ wdata;
      endcase
    end
  end

  // Hardware set pulses are merged after the software update so they win.
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= sw_next | hw_set;
  end

endmodule

// File: rtl/alias_read_port.sv
module alias_read_port #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd,
  input  logic                       hit,
  input  logic [IDX_W-1:0]           idx,
  input  logic [NUM_REGS*DATA_W-1:0] regs,
  output logic [DATA_W-1:0]          rdata
);

  logic [DATA_W-1:0] words [NUM_REGS];
  logic [DATA_W-1:0] sel;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_unpack
    assign words[i] = regs[i*DATA_W +: DATA_W];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit && idx == IDX_W'(i)) sel = words[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end

endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
  import alias_regbank_pkg::*;
#(
  parameter int                         ADDR_W     = 8,
  parameter int                         DATA_W     = 32,
  parameter int                         NUM_REGS   = 4,
  parameter logic [NUM_REGS-1:0]        RO_MASK    = 4'b1000,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS = {32'h0000_0000, 32'h0000_0000,
                                                      32'h1234_5678, 32'h0000_00A5}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_rd,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_REGS*DATA_W-1:0] hw_in,
  output logic [NUM_REGS*DATA_W-1:0] reg_q
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             hit;
  logic [IDX_W-1:0] idx;
  acc_mode_e        mode;
  logic             unused_byte_lanes;

  assign unused_byte_lanes = ^bus_addr[1:0];

  alias_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr_hi (bus_addr[ADDR_W-1:2]),
    .hit     (hit),
    .idx     (idx),
    .mode    (mode)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (RO_MASK[i]) begin : g_ro
      always_ff @(posedge clk) begin
        if (rst) reg_q[i*DATA_W +: DATA_W] <= RESET_VALS[i*DATA_W +: DATA_W];
        else     reg_q[i*DATA_W +: DATA_W] <= hw_in[i*DATA_W +: DATA_W];
      end
    end else begin : g_rw
      logic sel_wr;
      assign sel_wr = bus_wr && hit && (idx == IDX_W'(i));
      alias_rw_cell #(
        .DATA_W    (DATA_W),
        .RESET_VAL (RESET_VALS[i*DATA_W +: DATA_W])
      ) u_cell (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (sel_wr),
        .mode   (mode),
        .wdata  (bus_wdata),
        .hw_set (hw_in[i*DATA_W +: DATA_W]),
        .q      (reg_q[i*DATA_W +: DATA_W])
      );
    end
  end

  alias_read_port #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_read (
    .clk   (clk),
    .rst   (rst),
    .rd    (bus_rd),
    .hit   (hit),
    .idx   (idx),
    .regs  (reg_q),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/alias_regbank_chk.sv
module alias_regbank_chk #(
  parameter int                  ADDR_W   = 8,
  parameter int                  DATA_W   = 32,
  parameter int                  NUM_REGS = 4,
  parameter logic [NUM_REGS-1:0] RO_MASK  = '0
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:4]          slot,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NUM_REGS*DATA_W-1:0] hw_in,
  input logic [NUM_REGS*DATA_W-1:0] reg_q
);

  function automatic logic [NUM_REGS*DATA_W-1:0] ro_bits_f();
    logic [NUM_REGS*DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (RO_MASK[i]) m[i*DATA_W +: DATA_W] = '1;
    return m;
  endfunction

  localparam logic [NUM_REGS*DATA_W-1:0] RO_BITS = ro_bits_f();
  localparam logic [NUM_REGS*DATA_W-1:0] RW_BITS = ~RO_BITS;

  logic                       miss;
  logic [NUM_REGS*DATA_W-1:0] hw_rw;
  assign miss  = (int'(slot) >= NUM_REGS);
  assign hw_rw = hw_in & RW_BITS;

  // R1
  reset_rdata_chk: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0));

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R7
  ro_track_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((reg_q & RO_BITS) == ($past(hw_in) & RO_BITS)));

  // R8
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_rw != '0) |=> ((reg_q & $past(hw_rw)) == $past(hw_rw)));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && miss && hw_rw == '0) |=> ((reg_q & RW_BITS) == $past(reg_q & RW_BITS)));

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && miss) |=> (bus_rdata == '0));

endmodule

bind alias_regbank alias_regbank_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS),
  .RO_MASK  (RO_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slot      (bus_addr[ADDR_W-1:4]),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .hw_in     (hw_in),
  .reg_q     (reg_q)
);

// File: tb/alias_regbank_bench.sv
`timescale 1ns/1ps
module alias_regbank_bench;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NR = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [DW-1:0]   bus_wdata = '0;
  logic            bus_rd = 1'b0;
  logic [DW-1:0]   bus_rdata;
  logic [NR*DW-1:0] hw_in = '0;
  logic [NR*DW-1:0] reg_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_seen = 1'b0;

  always #4 clk = ~clk;

  alias_regbank #(
    .ADDR_W     (AW),
    .DATA_W     (DW),
    .NUM_REGS   (NR),
    .RO_MASK    (4'b1000),
    .RESET_VALS ({32'h0000_0000, 32'h0000_0000, 32'h1234_5678, 32'h0000_00A5})
  ) u_alias_regbank (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .hw_in     (hw_in),
    .reg_q     (reg_q)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(int i);
    return reg_q[i*DW +: DW];
  endfunction

  // Monitor: a read sampled at a rising edge is compared at the next falling edge.
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      automatic logic [DW-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, logic [DW-1:0] e, string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    logic [NR*DW-1:0] snap;
    repeat (3) @(negedge clk);
    // R1: reset values and cleared read data
    check("R1 reg0", word(0), 32'h0000_00A5);
    check("R1 reg1", word(1), 32'h1234_5678);
    check("R1 reg2", word(2), 32'h0000_0000);
    check("R1 rdata", bus_rdata, 32'h0);
    rst = 1'b0;

    // R6: read through different aliases
    bus_read(8'h00, 32'h0000_00A5, "R6 read reg0 load alias");
    bus_read(8'h14, 32'h1234_5678, "R6 read reg1 set alias");

    // R2..R5: the four write modes on reg0
    bus_write(8'h00, 32'hF0F0_0000);
    check("R2 load", word(0), 32'hF0F0_0000);
    bus_write(8'h04, 32'h0000_000F);
    check("R3 set", word(0), 32'hF0F0_000F);
    bus_write(8'h08, 32'hF000_0001);
    check("R4 clear", word(0), 32'h00F0_000E);
    bus_write(8'h0C, 32'hFF00_00FF);
    check("R5 toggle", word(0), 32'hFFF0_00F1);
    check("R2 neighbour reg1 untouched", word(1), 32'h1234_5678);
    bus_read(8'h0C, 32'hFFF0_00F1, "R6 read reg0 toggle alias");
    bus_read(8'h03, 32'hFFF0_00F1, "R6 low address bits ignored");

    // R6: read in the same cycle as a write returns the old value
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'h5555_AAAA; bus_wr = 1'b1; bus_rd = 1'b1;
    exp_q.push_back(32'hFFF0_00F1); tag_q.push_back("R6 read during write old value");
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R2 load with read", word(0), 32'h5555_AAAA);

    // R7: read-only register follows hw_in and ignores writes
    hw_in[3*DW +: DW] = 32'hDEAD_BEEF;
    bus_write(8'h30, 32'h0000_0000);
    bus_write(8'h34, 32'hFFFF_FFFF);
    bus_write(8'h38, 32'hFFFF_FFFF);
    bus_write(8'h3C, 32'hFFFF_FFFF);
    check("R7 ro ignores writes", word(3), 32'hDEAD_BEEF);
    bus_read(8'h38, 32'hDEAD_BEEF, "R7 ro read");

    // R8: hardware set beats a same-cycle software clear
    @(negedge clk);
    bus_addr = 8'h28; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
    hw_in[2*DW +: DW] = 32'h0000_0010;
    @(negedge clk);
    bus_wr = 1'b0; hw_in[2*DW +: DW] = '0;
    check("R8 set wins over clear", word(2), 32'h0000_0010);
    // R8: standalone hardware set on reg1
    @(negedge clk);
    hw_in[1*DW +: DW] = 32'h8000_0000;
    @(negedge clk);
    hw_in[1*DW +: DW] = '0;
    check("R8 hw set alone", word(1), 32'h9234_5678);
    bus_read(8'h1C, 32'h9234_5678, "R8 read back status bit");

    // R9: unmapped slots
    snap = reg_q;
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_write(8'hF8, 32'hFFFF_FFFF);
    check("R9 write no effect reg0", word(0), snap[0*DW +: DW]);
    check("R9 write no effect reg1", word(1), snap[1*DW +: DW]);
    check("R9 write no effect reg2", word(2), snap[2*DW +: DW]);
    bus_read(8'h50, 32'h0, "R9 unmapped read slot 5");
    bus_read(8'hF4, 32'h0, "R9 unmapped read slot 15");

    // R6: data holds without a read
    repeat (2) @(negedge clk);
    check("R6 rdata holds", bus_rdata, 32'h0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("queue drained", 32'(exp_q.size()), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule